// File: doc/BRIEF.md
# Read-to-Read Turnaround Spacer

This block sits in the command path of a DDR3 memory controller. It decides when a pending READ may be issued. The decision depends on the rank and DIMM of the previous READ. A READ to the same rank as the last issued READ is not held back. A READ that moves to another rank on the same DIMM, or to another DIMM, must wait a minimum number of DRAM clocks. That minimum is a fixed base of five clocks plus a 3-bit programmed offset. There is one offset for a rank change and a separate one for a DIMM change.

A cycle in which `rd_grant` is high is a cycle in which the READ's chip select is asserted. The gap is the difference between the grant cycles of the two READs. The block records the target of every granted READ. It starts two down-counters, one per offset kind, which load the required gap minus one. The offsets are sampled at the moment the earlier READ is granted.

Top module: `rd_turn_spacer`

## Requirements
- R1: After reset, the first requested READ is granted in the same cycle that `rd_req` is first seen high, whatever its target.
- R2: `rd_grant` is combinational from the current inputs and state, and is never high while `rd_req` is low.
- R3: A READ with the same `rd_dimm` and `rd_rank` as the last granted READ is granted at once; back-to-back grant cycles are possible.
- R4: A READ with the same `rd_dimm` but a different `rd_rank` is first granted exactly `rank_ofs + 5` cycles after the last granted READ, if it is requested throughout.
- R5: A READ with a different `rd_dimm` is first granted exactly `dimm_ofs + 5` cycles after the last granted READ, whatever its rank. With different offsets programmed, the DIMM offset is the one that applies.
- R6: No rank-change or DIMM-change READ is granted fewer than 5 cycles after the previous READ. An offset of 0 gives exactly 5.
- R7: The offset that applies is the value on `rank_ofs` or `dimm_ofs` in the cycle the earlier READ was granted. Changing it afterwards does not alter the pending gap.
- R8: The gap is always measured from the most recent granted READ. A same-rank READ restarts the window for a later rank change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | A READ is pending |
| rd_rank | input | RANK_W (2) | Rank within the DIMM targeted by the pending READ |
| rd_dimm | input | DIMM_W (1) | DIMM targeted by the pending READ |
| rank_ofs | input | OFS_W (3) | Extra clocks over the base for a rank change on one DIMM |
| dimm_ofs | input | OFS_W (3) | Extra clocks over the base for a change of DIMM |
| rd_grant | output | 1 | The pending READ is issued in this cycle |

## Verification
The hardest case to reach is a pending gap that was set under one offset value after that offset has already changed on the input. From the ports it looks identical to an ordinary wait. The stimulus grants a READ under the largest rank offset, lowers the offset in the following cycle while the rank-change READ is already waiting, and measures the gap. Only a design that sampled the offset at the earlier grant produces the long gap. The restart case is reached the same way: a same-rank READ is placed in the middle of an idle stretch, and the later rank-change gap must count from that READ rather than from the first one.

// File: rtl/rdsp_pkg.sv
package rdsp_pkg;

  // relation of a pending READ to the last granted one
  typedef enum logic [1:0] {
    K_FIRST = 2'd0,
    K_SAME  = 2'd1,
    K_RANK  = 2'd2,
    K_DIMM  = 2'd3
  } rd_kind_e;

  // required command spacing in clocks: base plus offset, never below the floor
  function automatic int unsigned req_gap(input int unsigned ofs,
                                          input int unsigned base,
                                          input int unsigned floor_v);
    int unsigned g;
    g = base + ofs;
    if (g < floor_v) g = floor_v;
    return g;
  endfunction

endpackage

// File: rtl/rdsp_classify.sv
module rdsp_classify
  import rdsp_pkg::*;
#(
  parameter int RANK_W = 2,
  parameter int DIMM_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [RANK_W-1:0] rank_in,
  input  logic [DIMM_W-1:0] dimm_in,
  output rd_kind_e          kind
);

  logic              seen_q;
  logic [RANK_W-1:0] last_rank_q;
  logic [DIMM_W-1:0] last_dimm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      last_rank_q <= '0;
      last_dimm_q <= '0;
    end else if (issue) begin
      seen_q      <= 1'b1;
      last_rank_q <= rank_in;
      last_dimm_q <= dimm_in;
    end
  end

  always_comb begin
    if (!seen_q)                    kind = K_FIRST;
    else if (dimm_in != last_dimm_q) kind = K_DIMM;
    else if (rank_in != last_rank_q) kind = K_RANK;
    else                             kind = K_SAME;
  end

  // the first READ after reset is never classified as a change
  AST_FIRST_ONLY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> kind != K_FIRST); // R1

endmodule

// File: rtl/rdsp_gap_timer.sv
module rdsp_gap_timer #(
  parameter int CNT_W   = 4,
  parameter int MAX_GAP = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] gap,
  output logic             ready
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= gap - CNT_W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign ready = (cnt_q == '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_GAP - 1)); // R6

  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    load && (gap > CNT_W'(1)) |=> !ready); // R6

endmodule

// File: rtl/rd_turn_spacer.sv
module rd_turn_spacer
  import rdsp_pkg::*;
#(
  parameter int RANK_W   = 2,
  parameter int DIMM_W   = 1,
  parameter int OFS_W    = 3,
  parameter int BASE_GAP = 5,
  parameter int MIN_GAP  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [RANK_W-1:0] rd_rank,
  input  logic [DIMM_W-1:0] rd_dimm,
  input  logic [OFS_W-1:0]  rank_ofs,
  input  logic [OFS_W-1:0]  dimm_ofs,
  output logic              rd_grant
);

  localparam int MAX_OFS = (1 << OFS_W) - 1;
  localparam int MAX_GAP = (BASE_GAP + MAX_OFS > MIN_GAP) ? BASE_GAP + MAX_OFS : MIN_GAP;
  localparam int CNT_W   = $clog2(MAX_GAP + 1);
  localparam int N_KIND  = 2;   // 0: rank change, 1: DIMM change

  rd_kind_e         kind;
  logic             issue;
  logic [OFS_W-1:0] ofs_a   [N_KIND];
  logic [CNT_W-1:0] gap_a   [N_KIND];
  logic             ready_a [N_KIND];

  assign ofs_a[0] = rank_ofs;
  assign ofs_a[1] = dimm_ofs;

  rdsp_classify #(.RANK_W(RANK_W), .DIMM_W(DIMM_W)) u_cls (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .rank_in (rd_rank),
    .dimm_in (rd_dimm),
    .kind    (kind)
  );

  for (genvar g = 0; g < N_KIND; g++) begin : g_tmr
    assign gap_a[g] = CNT_W'(req_gap(int'(ofs_a[g]), BASE_GAP, MIN_GAP));
    rdsp_gap_timer #(.CNT_W(CNT_W), .MAX_GAP(MAX_GAP)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (issue),
      .gap   (gap_a[g]),
      .ready (ready_a[g])
    );
  end

  always_comb begin
    unique case (kind)
      K_FIRST, K_SAME: rd_grant = rd_req;
      K_RANK:          rd_grant = rd_req && ready_a[0];
      K_DIMM:          rd_grant = rd_req && ready_a[1];
      default:         rd_grant = 1'b0;
    endcase
  end

  assign issue = rd_grant;

  // observation state: clocks since the last grant and the offsets seen then
  logic [CNT_W-1:0] since_q;
  logic [OFS_W-1:0] rank_ofs_q, dimm_ofs_q;
  logic [CNT_W-1:0] rank_need, dimm_need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q    <= '0;
      rank_ofs_q <= '0;
      dimm_ofs_q <= '0;
    end else begin
      if (issue) begin
        since_q    <= CNT_W'(1);
        rank_ofs_q <= rank_ofs;
        dimm_ofs_q <= dimm_ofs;
      end else if (since_q != '1) begin
        since_q <= since_q + CNT_W'(1);
      end
    end
  end

  assign rank_need = CNT_W'(BASE_GAP) + CNT_W'(rank_ofs_q);
  assign dimm_need = CNT_W'(BASE_GAP) + CNT_W'(dimm_ofs_q);

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |-> rd_req); // R2

  AST_FIRST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && kind == K_FIRST |-> rd_grant); // R1

  AST_SAME_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && kind == K_SAME |-> rd_grant); // R3

  AST_RANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant && kind == K_RANK |-> since_q >= rank_need); // R4

  AST_RANK_TIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && kind == K_RANK && since_q >= rank_need |-> rd_grant); // R4

  AST_DIMM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant && kind == K_DIMM |-> since_q >= dimm_need); // R5

  AST_DIMM_TIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && kind == K_DIMM && since_q >= dimm_need |-> rd_grant); // R5

  AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant && (kind == K_RANK || kind == K_DIMM) |-> since_q >= CNT_W'(MIN_GAP)); // R6

endmodule

// File: tb/sim_rd_turn_spacer.sv
module sim_rd_turn_spacer;

  localparam int CLK_P = 10;
  localparam int BASE  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_req = 1'b0;
  logic [1:0] rd_rank = '0;
  logic [0:0] rd_dimm = '0;
  logic [2:0] rank_ofs = 3'd2;
  logic [2:0] dimm_ofs = 3'd2;
  logic       rd_grant;

  int total = 0;
  int bad   = 0;
  int ncyc  = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  rd_turn_spacer u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_rank(rd_rank),
    .rd_dimm(rd_dimm), .rank_ofs(rank_ofs), .dimm_ofs(dimm_ofs),
    .rd_grant(rd_grant)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // request a READ at a negedge, hold it until granted; returns the grant cycle
  task automatic send(input int r, input int d, output int gcyc, output int t0);
    rd_rank = 2'(r);
    rd_dimm = 1'(d);
    rd_req  = 1'b1;
    t0 = ncyc;
    gcyc = -1;
    for (int i = 0; i < 40; i++) begin
      #1;
      if (rd_grant) begin
        gcyc = ncyc;
        @(negedge clk);
        rd_req = 1'b0;
        break;
      end
      @(negedge clk);
    end
    rd_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      #1;
      chk(rd_grant == 1'b0, "R2 no grant without request", rd_grant, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int g, t0;
    @(negedge clk);
    chk(rd_grant == 1'b0, "R2 reset grant low", rd_grant, 0);
    idle(3);
    send(2, 1, g, t0);
    chk(g == t0, "R1 first READ immediate", g - t0, 0);
  endtask

  task automatic t_same();
    int g1, g2, t0;
    idle(15);
    send(3, 0, g1, t0);
    send(3, 0, g2, t0);
    chk(g2 - g1 == 1, "R3 same rank back to back", g2 - g1, 1);
  endtask

  task automatic t_rank(input int ofs);
    int g1, g2, t0;
    rank_ofs = 3'(ofs);
    dimm_ofs = 3'd7;
    idle(15);
    send(0, 0, g1, t0);
    send(1, 0, g2, t0);
    chk(g2 - g1 == ofs + BASE, "R4 rank change gap", g2 - g1, ofs + BASE);
    if (ofs == 0) chk(g2 - g1 == BASE, "R6 floor with zero offset", g2 - g1, BASE);
  endtask

  task automatic t_dimm(input int ofs, input int r2);
    int g1, g2, t0;
    dimm_ofs = 3'(ofs);
    rank_ofs = 3'(7 - ofs);
    idle(15);
    send(1, 0, g1, t0);
    send(r2, 1, g2, t0);
    chk(g2 - g1 == ofs + BASE, "R5 DIMM change gap", g2 - g1, ofs + BASE);
    chk(g2 - g1 >= BASE, "R6 never below floor", g2 - g1, BASE);
  endtask

  task automatic t_sample();
    int g1, g2, t0;
    rank_ofs = 3'd7;
    idle(15);
    send(0, 1, g1, t0);
    rank_ofs = 3'd0;
    send(2, 1, g2, t0);
    chk(g2 - g1 == 12, "R7 offset sampled at earlier grant", g2 - g1, 12);
  endtask

  task automatic t_restart();
    int g1, g2, g3, t0;
    rank_ofs = 3'd2;
    idle(15);
    send(0, 0, g1, t0);
    idle(3);
    send(0, 0, g2, t0);
    chk(g2 == t0, "R3 same rank after idle immediate", g2 - t0, 0);
    send(1, 0, g3, t0);
    chk(g3 - g2 == 7, "R8 window restarts at latest READ", g3 - g2, 7);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_same();
        t_rank(0);
        t_rank(2);
        t_rank(5);
        t_rank(7);
        t_dimm(0, 1);
        t_dimm(3, 0);
        t_dimm(7, 2);
        t_sample();
        t_restart();
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) chk(1'b0, "watchdog", ncyc, 0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule